// File: doc/BRIEF.md
# Interleaved Two-Bank Command Queue

This block sits between a bus input register and two interleaved DRAM arrays. Each accepted command carries an address, write data, a read flag and a length code. Address bit 2 picks the array that owns the command: even words go to array A, odd words to array B. Each array has its own two-entry queue, so the block holds at most four pending commands. One output port presents the chosen entry to the array input latches. Two latch strobes tell each array whether to capture it.

All four slots share one age order. The oldest command is served first. A write may pass an older write that waits on a busy array, but it may not pass an older read. A read leaves only when it is the oldest entry and both arrays are ready. It then pulses both latch strobes so that the two arrays start the read together. A command aimed at a half that already holds two entries is refused with a same-cycle reject and is not stored.

Top module: `ilv_cmd_queue`

## Requirements
- R1: `ld_ctl` shows how the input is steered in the current cycle. `00` loads half A (address bit 2 is 0). `01` loads half B (address bit 2 is 1). `10` holds, used when there is no command or the command is rejected. The code `11` never appears.
- R2: Loading into a half whose newer slot (slot 1) is occupied moves that entry into the older slot (slot 2). The new command then takes slot 1.
- R3: When `in_valid` is high and the target half holds two entries, `in_nack` is high in the same cycle. The queue contents stay unchanged.
- R4: `full_flags` bit 0 is A1, bit 1 is A2, bit 2 is B1 and bit 3 is B2. A bit is 1 while that slot holds a command.
- R5: `sel` names the slot being issued: `00` is B2, `01` is B1, `10` is A2 and `11` is A1. The issued entry is always an occupied slot.
- R6: In a cycle with no issue, `latch_a` and `latch_b` are both low and `sel` is `00`.
- R7: Among the issuable queue heads, the older one is issued. At most one entry is issued per cycle.
- R8: A read is issued only when it is the oldest queued command and `rdy_a` and `rdy_b` are both high. When it issues, `latch_a` and `latch_b` are both high.
- R9: A write is issued, with only its own array's latch strobe, when that array is ready and no older read is queued. This holds even when an older write in the other half is stalled.
- R10: Issuing slot 1 while slot 2 is empty clears only slot 1. Issuing slot 2 leaves the slot 1 entry in place as the sole entry of that half.
- R11: A synchronous active-high reset empties all four slots.
- R12: `out_addr`, `out_data`, `out_read` and `out_len` carry the fields of the slot named by `sel` while a latch strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded array command is present |
| in_addr | input | 32 | Command address; bit 2 selects the half |
| in_data | input | 32 | Write data |
| in_read | input | 1 | 1 for a read, 0 for a write or partial write |
| in_len | input | 3 | Length code, carried through unchanged |
| in_nack | output | 1 | Reject: the target half is full |
| ld_ctl | output | 2 | Load steering code |
| rdy_a | input | 1 | Array A can accept a command |
| rdy_b | input | 1 | Array B can accept a command |
| latch_a | output | 1 | Array A captures the presented command |
| latch_b | output | 1 | Array B captures the presented command |
| sel | output | 2 | Slot being presented |
| out_addr | output | 32 | Presented address |
| out_data | output | 32 | Presented data |
| out_read | output | 1 | Presented read flag |
| out_len | output | 3 | Presented length code |
| full_flags | output | 4 | Per-slot occupancy |

## Verification
A load into one half and an issue from a queue can happen on the same clock edge. This case exercises the slot shift and the age re-ranking together. The bench provokes it in two ways. In one, it loads half B while the oldest write leaves half A. In the other, it loads half A while the single entry of half A issues. After the edge it checks that the occupancy flags match the expected slot layout. It also checks the next issue order, which shows that the new entry ranks youngest and that the older survivor was neither lost nor overwritten.

// File: rtl/ilvq_pkg.sv
package ilvq_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int LEN_W   = 3;
    localparam int NSLOT   = 4;
    localparam int RANK_W  = $clog2(NSLOT);
    localparam int OCC_W   = $clog2(NSLOT + 1);

    typedef enum logic [1:0] {
        LD_A    = 2'b00,
        LD_B    = 2'b01,
        LD_HOLD = 2'b10
    } ld_ctl_e;

    typedef enum logic [1:0] {
        SEL_B2 = 2'b00,
        SEL_B1 = 2'b01,
        SEL_A2 = 2'b10,
        SEL_A1 = 2'b11
    } sel_e;

    typedef struct packed {
        logic              is_read;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    // rank 0 is the oldest occupied slot
    typedef struct packed {
        logic              vld;
        logic [RANK_W-1:0] rank;
        cmd_t              cmd;
    } slot_t;

    // rank of a surviving entry after the entry of rank gone_rank leaves
    function automatic logic [RANK_W-1:0] rank_after(
        input logic [RANK_W-1:0] rank,
        input logic              gone,
        input logic [RANK_W-1:0] gone_rank
    );
        if (gone && (rank > gone_rank))
            return rank - 1'b1;
        return rank;
    endfunction

    // is slot s a read that is older than rank r
    function automatic logic older_read(input slot_t s, input logic [RANK_W-1:0] r);
        return s.vld && s.cmd.is_read && (s.rank < r);
    endfunction

endpackage

// File: rtl/ilvq_half.sv
module ilvq_half
    import ilvq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  cmd_t              load_cmd,
    input  logic [RANK_W-1:0] load_rank,
    input  logic              pop,
    input  logic              dec_vld,
    input  logic [RANK_W-1:0] dec_rank,
    output slot_t             s1,
    output slot_t             s2,
    output logic              half_full
);

    slot_t s1_n, s2_n, s1_adj, s2_adj;
    logic  pop_s1, pop_s2, s1_stays;

    assign half_full = s1.vld && s2.vld;
    assign pop_s1    = pop && !s2.vld;
    assign pop_s2    = pop && s2.vld;
    assign s1_stays  = s1.vld && !pop_s1;

    always_comb begin
        s1_adj      = s1;
        s1_adj.rank = rank_after(s1.rank, dec_vld, dec_rank);
        s2_adj      = s2;
        s2_adj.rank = rank_after(s2.rank, dec_vld, dec_rank);

        s1_n = s1_adj;
        s2_n = s2_adj;
        if (pop_s1) s1_n.vld = 1'b0;
        if (pop_s2) s2_n.vld = 1'b0;

        if (load) begin
            if (s1_stays) s2_n = s1_adj;
            s1_n.vld  = 1'b1;
            s1_n.rank = load_rank;
            s1_n.cmd  = load_cmd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= s1_n;
            s2 <= s2_n;
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        load |-> !half_full);

    assert_shift_on_load_R2: assert property (@(posedge clk) disable iff (rst)
        (load && s1.vld && !pop_s1) |=> (s2.vld && s2.cmd == $past(s1.cmd)));

    assert_older_pop_keeps_newer_R10: assert property (@(posedge clk) disable iff (rst)
        (pop_s2 && s1.vld && !load) |=> (s1.vld && !s2.vld && s1.cmd == $past(s1.cmd)));

    assert_newer_pop_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (pop_s1 && !load) |=> (!s1.vld && !s2.vld));

endmodule

// File: rtl/ilvq_arbiter.sv
module ilvq_arbiter
    import ilvq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  slot_t             a1,
    input  slot_t             a2,
    input  slot_t             b1,
    input  slot_t             b2,
    input  logic              rdy_a,
    input  logic              rdy_b,
    output sel_e              sel,
    output logic              latch_a,
    output logic              latch_b,
    output logic              pop_a,
    output logic              pop_b,
    output logic [RANK_W-1:0] pop_rank
);

    slot_t head_a, head_b;
    logic  hv_a, hv_b, oldest_a, oldest_b;
    logic  blk_a, blk_b, elig_a, elig_b;

    assign head_a = a2.vld ? a2 : a1;
    assign head_b = b2.vld ? b2 : b1;
    assign hv_a   = a1.vld || a2.vld;
    assign hv_b   = b1.vld || b2.vld;

    assign oldest_a = hv_a && (!hv_b || head_a.rank < head_b.rank);
    assign oldest_b = hv_b && (!hv_a || head_b.rank < head_a.rank);

    // a write may not pass a read queued in the other half that is older
    assign blk_a = older_read(b1, head_a.rank) || older_read(b2, head_a.rank);
    assign blk_b = older_read(a1, head_b.rank) || older_read(a2, head_b.rank);

    assign elig_a = hv_a && (head_a.cmd.is_read ? (oldest_a && rdy_a && rdy_b)
                                                : (rdy_a && !blk_a));
    assign elig_b = hv_b && (head_b.cmd.is_read ? (oldest_b && rdy_a && rdy_b)
                                                : (rdy_b && !blk_b));

    assign pop_a = elig_a && (!elig_b || oldest_a);
    assign pop_b = elig_b && !pop_a;

    assign latch_a = pop_a || (pop_b && head_b.cmd.is_read);
    assign latch_b = pop_b || (pop_a && head_a.cmd.is_read);

    always_comb begin
        sel      = SEL_B2;
        pop_rank = '0;
        if (pop_a) begin
            sel      = a2.vld ? SEL_A2 : SEL_A1;
            pop_rank = head_a.rank;
        end else if (pop_b) begin
            sel      = b2.vld ? SEL_B2 : SEL_B1;
            pop_rank = head_b.rank;
        end
    end

    assert_single_issue_R7: assert property (@(posedge clk) disable iff (rst)
        !(pop_a && pop_b));

    assert_read_needs_both_R8: assert property (@(posedge clk) disable iff (rst)
        (latch_a && latch_b) |-> (rdy_a && rdy_b));

    assert_write_own_ready_R9: assert property (@(posedge clk) disable iff (rst)
        (latch_a != latch_b) |-> ((latch_a && rdy_a) || (latch_b && rdy_b)));

endmodule

// File: rtl/ilv_cmd_queue.sv
module ilv_cmd_queue
    import ilvq_pkg::*;
#(
    parameter int ILV_BIT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_read,
    input  logic [LEN_W-1:0]  in_len,
    output logic              in_nack,
    output logic [1:0]        ld_ctl,
    input  logic              rdy_a,
    input  logic              rdy_b,
    output logic              latch_a,
    output logic              latch_b,
    output logic [1:0]        sel,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic              out_read,
    output logic [LEN_W-1:0]  out_len,
    output logic [NSLOT-1:0]  full_flags
);

    localparam int NHALF = 2;

    slot_t             s1_q [NHALF];
    slot_t             s2_q [NHALF];
    logic [NHALF-1:0]  half_full;
    logic [NHALF-1:0]  pop_h;
    logic              tgt_b, accept, issue, pop_a, pop_b;
    logic [RANK_W-1:0] pop_rank, new_rank;
    logic [OCC_W-1:0]  occ;
    cmd_t              in_cmd, out_cmd;
    sel_e              sel_w;
    ld_ctl_e           ld_w;

    assign tgt_b   = in_addr[ILV_BIT];
    assign in_nack = in_valid && half_full[tgt_b];
    assign accept  = in_valid && !half_full[tgt_b];
    assign ld_w    = !accept ? LD_HOLD : (tgt_b ? LD_B : LD_A);
    assign ld_ctl  = ld_w;

    assign in_cmd.is_read = in_read;
    assign in_cmd.len     = in_len;
    assign in_cmd.addr    = in_addr;
    assign in_cmd.data    = in_data;

    assign full_flags = {s2_q[1].vld, s1_q[1].vld, s2_q[0].vld, s1_q[0].vld};
    assign issue      = pop_a || pop_b;
    assign occ        = OCC_W'($countones(full_flags));
    assign new_rank   = RANK_W'(occ - OCC_W'(issue));
    assign pop_h      = {pop_b, pop_a};

    for (genvar g = 0; g < NHALF; g++) begin : g_half
        ilvq_half u_half (
            .clk       (clk),
            .rst       (rst),
            .load      (accept && (tgt_b == g[0])),
            .load_cmd  (in_cmd),
            .load_rank (new_rank),
            .pop       (pop_h[g]),
            .dec_vld   (issue),
            .dec_rank  (pop_rank),
            .s1        (s1_q[g]),
            .s2        (s2_q[g]),
            .half_full (half_full[g])
        );
    end

    ilvq_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .a1       (s1_q[0]),
        .a2       (s2_q[0]),
        .b1       (s1_q[1]),
        .b2       (s2_q[1]),
        .rdy_a    (rdy_a),
        .rdy_b    (rdy_b),
        .sel      (sel_w),
        .latch_a  (latch_a),
        .latch_b  (latch_b),
        .pop_a    (pop_a),
        .pop_b    (pop_b),
        .pop_rank (pop_rank)
    );

    assign sel = sel_w;

    always_comb begin
        unique case (sel_w)
            SEL_A1:  out_cmd = s1_q[0].cmd;
            SEL_A2:  out_cmd = s2_q[0].cmd;
            SEL_B1:  out_cmd = s1_q[1].cmd;
            default: out_cmd = s2_q[1].cmd;
        endcase
    end

    assign out_addr = out_cmd.addr;
    assign out_data = out_cmd.data;
    assign out_read = out_cmd.is_read;
    assign out_len  = out_cmd.len;

    assert_ld_code_legal_R1: assert property (@(posedge clk) disable iff (rst)
        ld_ctl != 2'b11);

    assert_nack_no_load_R3: assert property (@(posedge clk) disable iff (rst)
        in_nack |-> (ld_ctl == LD_HOLD));

    assert_issue_from_full_R5: assert property (@(posedge clk) disable iff (rst)
        (latch_a || latch_b) |-> full_flags[2'd3 - sel]);

    assert_idle_default_R6: assert property (@(posedge clk) disable iff (rst)
        !(latch_a || latch_b) |-> (sel == SEL_B2));

    assert_flags_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!accept && !latch_a && !latch_b) |=> $stable(full_flags));

endmodule

// File: tb/ilv_cmd_queue_bench.sv
module ilv_cmd_queue_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_read, rdy_a, rdy_b;
    logic [31:0] in_addr, in_data;
    logic [2:0]  in_len;
    logic        in_nack, latch_a, latch_b, out_read;
    logic [1:0]  ld_ctl, sel;
    logic [31:0] out_addr, out_data;
    logic [2:0]  out_len;
    logic [3:0]  full_flags;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ilv_cmd_queue u_ilv_cmd_queue (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
        .in_data(in_data), .in_read(in_read), .in_len(in_len),
        .in_nack(in_nack), .ld_ctl(ld_ctl), .rdy_a(rdy_a), .rdy_b(rdy_b),
        .latch_a(latch_a), .latch_b(latch_b), .sel(sel),
        .out_addr(out_addr), .out_data(out_data), .out_read(out_read),
        .out_len(out_len), .full_flags(full_flags)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // fields: valid, a2, read, rdy_a, rdy_b, id[5], nack, ld[2], la, lb, sel[2], issued id[5], flags after edge[4]
    localparam int NV = 24;
    localparam logic [25:0] VEC [NV] = '{
        26'b1_0_0_0_0_00001_0_00_0_0_00_00000_0001, // load A1
        26'b1_0_0_0_0_00010_0_00_0_0_00_00000_0011, // R2 shift into A2
        26'b1_0_0_0_0_00011_1_10_0_0_00_00000_0011, // R3 A full
        26'b1_1_1_0_0_00100_0_01_0_0_00_00000_0111, // read into B1
        26'b0_0_0_0_1_00000_0_10_0_0_00_00000_0111, // R8 young read waits
        26'b0_0_0_1_1_00000_0_10_1_0_10_00001_0101, // R10 A2 leaves, A1 stays
        26'b0_0_0_0_1_00000_0_10_0_0_00_00000_0101, // R8 read not oldest
        26'b1_1_0_1_1_00101_0_01_1_0_11_00010_1100, // load B with issue from A
        26'b0_0_0_1_0_00000_0_10_0_0_00_00000_1100, // R8 rdy_b low
        26'b0_0_0_1_1_00000_0_10_1_1_00_00100_0100, // R8 read, both strobes
        26'b1_0_0_1_0_00110_0_00_0_0_00_00000_0101,
        26'b0_0_0_1_0_00000_0_10_1_0_11_00110_0100, // R9 bypass stalled write
        26'b1_0_1_0_0_00111_0_00_0_0_00_00000_0101,
        26'b1_1_0_1_0_01000_0_01_0_0_00_00000_1101, // R8 read not oldest
        26'b0_0_0_1_1_00000_0_10_0_1_00_00101_0101, // R7 oldest write
        26'b0_0_0_0_1_00000_0_10_0_0_00_00000_0101, // R9 write behind older read
        26'b0_0_0_1_1_00000_0_10_1_1_11_00111_0100, // R8 read from A1
        26'b0_0_0_1_1_00000_0_10_0_1_01_01000_0000, // R10 B1 alone leaves
        26'b1_0_0_0_0_01001_0_00_0_0_00_00000_0001,
        26'b1_0_0_1_0_01010_0_00_1_0_11_01001_0001, // load A while A1 leaves
        26'b0_0_0_1_0_00000_0_10_1_0_11_01010_0000,
        26'b1_1_0_0_0_01011_0_01_0_0_00_00000_0100,
        26'b1_1_0_0_0_01100_0_01_0_0_00_00000_1100,
        26'b1_1_0_0_0_01101_1_10_0_0_00_00000_1100  // R3 B full
    };

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; in_valid = 0; in_read = 0; in_addr = '0; in_data = '0;
        in_len = 3'd4; rdy_a = 0; rdy_b = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        check("R11", "flags after reset", 32'(full_flags), 32'h0);
        check("R6", "sel idle", 32'(sel), 32'h0);
        check("R6", "latches idle", 32'({latch_a, latch_b}), 32'h0);
        check("R1", "ld idle", 32'(ld_ctl), 32'h2);

        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            v = VEC[i];
            @(negedge clk);
            in_valid = v[25];
            in_read  = v[23];
            rdy_a    = v[22];
            rdy_b    = v[21];
            in_addr  = {24'h0, v[20:16], v[24], 2'b00};
            in_data  = ~in_addr;
            in_len   = v[23] ? 3'd5 : 3'd4;
            #2;
            check("R3", "nack", 32'(in_nack), 32'(v[15]));
            check("R1", "ld_ctl", 32'(ld_ctl), 32'(v[14:13]));
            check("R8/R9", "latch_a", 32'(latch_a), 32'(v[12]));
            check("R8/R9", "latch_b", 32'(latch_b), 32'(v[11]));
            check("R5/R6", "sel", 32'(sel), 32'(v[10:9]));
            if (v[12] || v[11]) begin
                check("R7", "issued id", 32'(out_addr[7:3]), 32'(v[8:4]));
                check("R12", "issued data", out_data, ~out_addr);
            end
            @(posedge clk);
            #1;
            check("R4/R2/R10", "flags", 32'(full_flags), 32'(v[3:0]));
        end

        // R11: reset while half B holds two entries
        @(negedge clk);
        in_valid = 0; rdy_a = 0; rdy_b = 0;
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R11", "flags cleared", 32'(full_flags), 32'h0);
        @(negedge clk);
        rst = 1'b0;
        rdy_a = 1; rdy_b = 1;
        #2;
        check("R11", "no issue after reset", 32'({latch_a, latch_b}), 32'h0);
        check("R6", "sel after reset", 32'(sel), 32'h0);

        // R12: read fields presented with both strobes
        @(negedge clk);
        rdy_a = 0; rdy_b = 0;
        in_valid = 1; in_read = 1; in_len = 3'd7; in_addr = 32'h0000_00F4; in_data = 32'h1234_5678;
        @(negedge clk);
        in_valid = 0; rdy_a = 1; rdy_b = 1;
        #2;
        check("R12", "out_addr", out_addr, 32'h0000_00F4);
        check("R12", "out_len", 32'(out_len), 32'd7);
        check("R12", "out_read", 32'(out_read), 32'd1);
        check("R8", "both strobes", 32'({latch_a, latch_b}), 32'h3);
        check("R5", "sel B1", 32'(sel), 32'h1);
        @(posedge clk);
        #1;
        check("R10", "flags empty", 32'(full_flags), 32'h0);
        summary();
    end

endmodule